// File: doc/BRIEF.md
# Sector Decoder Status Flags and Interrupt Request

This block keeps the interrupt-related status flags of an optical-disc sector decoder. Two active-low flags drive its interrupt. One flag reports that a sector decode has completed. The other reports that a host data transfer has ended. A third active-low flag reports that a transfer is busy. A fourth bit, active high, marks the decoder status as valid. The block presents these flags as two status bytes and combines the two interrupt flags into one active-low interrupt line.

The decode flag drops when a decode finishes. It restores itself after a programmable number of clock cycles. A read of the decoder status register also restores it, at once. A control write that turns data output off ends any transfer and releases both transfer flags. The interrupt request is raised only when the combined line falls. It stays set until the host acknowledges it. A falling edge seen in the same cycle as the acknowledge is dropped.

Top module: `dec_irq_flags`

## Requirements
- R1: After reset, `ifstat_o` reads 0xFF, `stat3_o` reads 0x80, `int_n_o` is 1 and `irq_req_o` is 0. The bits of `ifstat_o` are: bit 0 decode flag (active low), bit 1 transfer-end flag (active low), bit 2 transfer-busy flag (active low). The other bits of `ifstat_o` always read 1. Bit 7 of `stat3_o` is the valid bit, and its other bits read 0.
- R2: A cycle with `decode_done` high drives `ifstat_o` bit 0 and `stat3_o` bit 7 to 0 on the next clock edge.
- R3: Once bit 0 of `ifstat_o` has dropped, it returns to 1 by itself exactly RESTORE_CYCLES clock cycles later, unless something else acts on it first.
- R4: A cycle with `stat_rd` high sets `ifstat_o` bit 0 and `stat3_o` bit 7 to 1 on the next edge and cancels any pending restore. If `decode_done` is high in the same cycle, the decode wins.
- R5: A `decode_done` that arrives while a restore is pending restarts the RESTORE_CYCLES count from the new completion.
- R6: `ctrl_wr` with `ctrl_oen`=1 drives bit 2 of `ifstat_o` to 0 and bit 1 to 1 on the next edge.
- R7: `xfer_done` while bit 2 of `ifstat_o` is 0 drives bit 1 to 0 and bit 2 to 1. While bit 2 is 1, `xfer_done` has no effect.
- R8: `ctrl_wr` with `ctrl_oen`=0 drives bits 1 and 2 of `ifstat_o` to 1 on the next edge, and it takes priority over a `xfer_done` in the same cycle.
- R9: `int_n_o` is the AND of `ifstat_o` bits 0 and 1. `irq_req_o` rises one cycle after `int_n_o` falls and never rises while `int_n_o` simply stays low.
- R10: `irq_ack` clears `irq_req_o` on the next edge. A falling edge detected in the ack cycle is dropped, and later falling edges set the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decode_done | input | 1 | One-cycle pulse when a sector decode finishes |
| stat_rd | input | 1 | Strobe for a read of the decoder status register |
| ctrl_wr | input | 1 | Strobe for a write of the control register |
| ctrl_oen | input | 1 | Data-output-enable bit carried by the control write |
| xfer_done | input | 1 | One-cycle pulse when a host transfer completes |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| ifstat_o | output | 8 | Interface status byte (flag bits listed in R1) |
| stat3_o | output | 8 | Decoder status byte, valid bit at bit 7 |
| int_n_o | output | 1 | Combined active-low interrupt line |
| irq_req_o | output | 1 | Interrupt request, set on a falling edge of `int_n_o` |

## Verification
Every flag change lands on the clock edge that samples its strobe. The status bytes and `int_n_o` therefore show the new value one cycle after the strobe, and `irq_req_o` shows it one cycle after that. Restore timing is checked on both sides of the boundary: the flag must still be low RESTORE_CYCLES-1 cycles after the drop and high one cycle later, and this check is repeated for a restarted count. Stimulus is driven on the falling clock edge and every result is sampled on a later falling edge, counted from the strobe, so each check lands in the cycle the requirement names.

// File: rtl/dec_irq_pkg.sv
package dec_irq_pkg;
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned POS_DEC_N  = 0;
  localparam int unsigned POS_XEND_N = 1;
  localparam int unsigned POS_BUSY_N = 2;
  localparam int unsigned POS_VALID  = STAT_W - 1;

  typedef logic [STAT_W-1:0] stat_byte_t;

  typedef struct packed {
    logic dec_n;
    logic xend_n;
    logic busy_n;
    logic valid;
  } flag_set_t;
endpackage

// File: rtl/dec_restore_timer.sv
module dec_restore_timer #(
  parameter int unsigned RESTORE_CYCLES = 575
) (
  input  logic clk,
  input  logic rst,
  input  logic decode_done,
  input  logic stat_rd,
  output logic dec_n,
  output logic valid
);
  localparam int unsigned CW = $clog2(RESTORE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_n  <= 1'b1;
      valid  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (decode_done) begin
      dec_n  <= 1'b0;
      valid  <= 1'b0;
      pend_q <= 1'b1;
      cnt_q  <= CW'(RESTORE_CYCLES - 1);
    end else if (stat_rd) begin
      dec_n  <= 1'b1;
      valid  <= 1'b1;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        dec_n  <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R2: a completion lowers the flag and the valid bit
  a_r2_done_clears: assert property (@(posedge clk) disable iff (rst)
    decode_done |=> (!dec_n && !valid));
  // R4: a read without a completion raises the flag
  a_r4_read_sets: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !decode_done) |=> (dec_n && valid));
  // R3: a low flag always has a restore in flight
  a_r3_low_pending: assert property (@(posedge clk) disable iff (rst)
    !dec_n |-> pend_q);
  // R3: the count never exceeds its window
  a_r3_window: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> (cnt_q < CW'(RESTORE_CYCLES)));
endmodule

// File: rtl/xfer_flag_ctrl.sv
module xfer_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic ctrl_oen,
  input  logic xfer_done,
  output logic xend_n,
  output logic busy_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      xend_n <= 1'b1;
      busy_n <= 1'b1;
    end else if (ctrl_wr && !ctrl_oen) begin
      xend_n <= 1'b1;
      busy_n <= 1'b1;
    end else if (ctrl_wr && ctrl_oen) begin
      xend_n <= 1'b1;
      busy_n <= 1'b0;
    end else if (xfer_done && !busy_n) begin
      xend_n <= 1'b0;
      busy_n <= 1'b1;
    end
  end

  // R8: disabling output releases both flags
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !ctrl_oen) |=> (xend_n && busy_n));
  // R6: enabling output marks the transfer busy
  a_r6_start: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_oen) |=> (!busy_n && xend_n));
  // R7: end flag only falls out of a busy transfer
  a_r7_end_from_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(xend_n) |-> $past(!busy_n && xfer_done));
endmodule

// File: rtl/irq_edge_gen.sv
module irq_edge_gen (
  input  logic clk,
  input  logic rst,
  input  logic int_n,
  input  logic irq_ack,
  output logic irq_req
);
  logic prev_q;
  logic fall;

  assign fall = prev_q && !int_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      irq_req <= 1'b0;
    end else begin
      prev_q <= int_n;
      if (irq_ack)   irq_req <= 1'b0;
      else if (fall) irq_req <= 1'b1;
    end
  end

  // R9: a new request needs a falling line
  a_r9_edge_only: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> ($past(prev_q) && !$past(int_n)));
  // R10: acknowledge clears the request
  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_req);
endmodule

// File: rtl/dec_irq_flags.sv
module dec_irq_flags
  import dec_irq_pkg::*;
#(
  parameter int unsigned RESTORE_CYCLES = 575
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                decode_done,
  input  logic                stat_rd,
  input  logic                ctrl_wr,
  input  logic                ctrl_oen,
  input  logic                xfer_done,
  input  logic                irq_ack,
  output logic [STAT_W-1:0]   ifstat_o,
  output logic [STAT_W-1:0]   stat3_o,
  output logic                int_n_o,
  output logic                irq_req_o
);
  flag_set_t fl;

  dec_restore_timer #(.RESTORE_CYCLES(RESTORE_CYCLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .decode_done (decode_done),
    .stat_rd     (stat_rd),
    .dec_n       (fl.dec_n),
    .valid       (fl.valid)
  );

  xfer_flag_ctrl u_xfer (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr),
    .ctrl_oen  (ctrl_oen),
    .xfer_done (xfer_done),
    .xend_n    (fl.xend_n),
    .busy_n    (fl.busy_n)
  );

  assign int_n_o = fl.dec_n & fl.xend_n;

  irq_edge_gen u_irq (
    .clk     (clk),
    .rst     (rst),
    .int_n   (int_n_o),
    .irq_ack (irq_ack),
    .irq_req (irq_req_o)
  );

  stat_byte_t ifs, st3;
  always_comb begin
    ifs             = '1;
    ifs[POS_DEC_N]  = fl.dec_n;
    ifs[POS_XEND_N] = fl.xend_n;
    ifs[POS_BUSY_N] = fl.busy_n;
    st3             = '0;
    st3[POS_VALID]  = fl.valid;
  end
  assign ifstat_o = ifs;
  assign stat3_o  = st3;

  // R1: out of reset all flags idle and no request
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (ifstat_o == '1 && !irq_req_o));
endmodule

// File: tb/dec_irq_flags_bench.sv
module dec_irq_flags_bench;
  localparam int unsigned RC = 575;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic decode_done = 0, stat_rd = 0, ctrl_wr = 0, ctrl_oen = 0, xfer_done = 0, irq_ack = 0;
  logic [7:0] ifstat_o, stat3_o;
  logic int_n_o, irq_req_o;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dec_irq_flags #(.RESTORE_CYCLES(RC)) u_dec_irq_flags (
    .clk(clk), .rst(rst), .decode_done(decode_done), .stat_rd(stat_rd),
    .ctrl_wr(ctrl_wr), .ctrl_oen(ctrl_oen), .xfer_done(xfer_done),
    .irq_ack(irq_ack), .ifstat_o(ifstat_o), .stat3_o(stat3_o),
    .int_n_o(int_n_o), .irq_req_o(irq_req_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic p_done; decode_done = 1; tick(1); decode_done = 0; endtask
  task automatic p_rd;   stat_rd = 1;     tick(1); stat_rd = 0;     endtask
  task automatic p_ack;  irq_ack = 1;     tick(1); irq_ack = 0;     endtask
  task automatic p_xd;   xfer_done = 1;   tick(1); xfer_done = 0;   endtask
  task automatic p_ctrl(input logic oen);
    ctrl_wr = 1; ctrl_oen = oen; tick(1); ctrl_wr = 0; ctrl_oen = 0;
  endtask

  task automatic t_reset;
    chk("R1 ifstat", ifstat_o, 8'hFF);
    chk("R1 stat3", stat3_o, 8'h80);
    chk("R1 int_n", {7'd0, int_n_o}, 8'd1);
    chk("R1 irq", {7'd0, irq_req_o}, 8'd0);
  endtask

  task automatic t_decode;
    p_done;
    chk("R2 ifstat", ifstat_o, 8'hFE);
    chk("R2 stat3", stat3_o, 8'h00);
    chk("R9 int_n low", {7'd0, int_n_o}, 8'd0);
    chk("R9 irq not yet", {7'd0, irq_req_o}, 8'd0);
    tick(1);
    chk("R9 irq raised", {7'd0, irq_req_o}, 8'd1);
    p_ack;
    chk("R10 ack clears", {7'd0, irq_req_o}, 8'd0);
    p_rd;
  endtask

  task automatic t_restore;
    p_done;
    tick(RC - 1);
    chk("R3 still low", ifstat_o, 8'hFE);
    tick(1);
    chk("R3 restored", ifstat_o, 8'hFF);
    chk("R3 valid stays clear", stat3_o, 8'h00);
    p_ack;
    tick(2);
    chk("R9 rising no irq", {7'd0, irq_req_o}, 8'd0);
    p_rd;
  endtask

  task automatic t_read;
    p_done;
    tick(5);
    p_ack;
    p_rd;
    chk("R4 read sets flag", ifstat_o, 8'hFF);
    chk("R4 read sets valid", stat3_o, 8'h80);
    tick(RC + 5);
    chk("R4 stays high", ifstat_o, 8'hFF);
    chk("R4 no irq", {7'd0, irq_req_o}, 8'd0);
    decode_done = 1; stat_rd = 1; tick(1); decode_done = 0; stat_rd = 0;
    chk("R4 decode wins flag", ifstat_o, 8'hFE);
    chk("R4 decode wins valid", stat3_o, 8'h00);
    tick(1);
    p_ack;
    p_rd;
  endtask

  task automatic t_retrigger;
    p_done;
    tick(299);
    p_done;
    tick(RC - 300);
    chk("R5 not restored at first deadline", ifstat_o, 8'hFE);
    tick(299);
    chk("R5 low before new deadline", ifstat_o, 8'hFE);
    tick(1);
    chk("R5 restored at new deadline", ifstat_o, 8'hFF);
    p_ack;
    p_rd;
  endtask

  task automatic t_xfer;
    p_ctrl(1'b1);
    chk("R6 busy", ifstat_o, 8'hFB);
    p_xd;
    chk("R7 end", ifstat_o, 8'hFD);
    chk("R9 int_n from end", {7'd0, int_n_o}, 8'd0);
    tick(1);
    chk("R9 irq from end", {7'd0, irq_req_o}, 8'd1);
    p_ack;
    p_ctrl(1'b0);
    chk("R8 release", ifstat_o, 8'hFF);
  endtask

  task automatic t_abort;
    p_ctrl(1'b1);
    p_ctrl(1'b0);
    chk("R8 abort", ifstat_o, 8'hFF);
    p_xd;
    chk("R7 ignored when idle", ifstat_o, 8'hFF);
    tick(1);
    chk("R7 no irq when idle", {7'd0, irq_req_o}, 8'd0);
    p_ctrl(1'b1);
    ctrl_wr = 1; ctrl_oen = 0; xfer_done = 1; tick(1);
    ctrl_wr = 0; xfer_done = 0;
    chk("R8 wins over end", ifstat_o, 8'hFF);
  endtask

  task automatic t_level;
    p_done;
    tick(1);
    p_ack;
    p_ctrl(1'b1);
    p_xd;
    chk("R7 end while decode low", ifstat_o, 8'hFC);
    tick(2);
    chk("R9 no irq on held low", {7'd0, irq_req_o}, 8'd0);
    p_ctrl(1'b0);
    p_rd;
    chk("R9 int_n back high", {7'd0, int_n_o}, 8'd1);
  endtask

  task automatic t_ack_same;
    decode_done = 1; tick(1); decode_done = 0;
    irq_ack = 1; tick(1); irq_ack = 0;
    chk("R10 edge in ack cycle dropped", {7'd0, irq_req_o}, 8'd0);
    p_rd;
    p_done;
    tick(1);
    chk("R10 later edge sets", {7'd0, irq_req_o}, 8'd1);
    p_ack;
    p_rd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    t_reset;
    t_decode;
    t_restore;
    t_read;
    t_retrigger;
    t_xfer;
    t_abort;
    t_level;
    t_ack_same;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule